// File: doc/BRIEF.md
# Shared-Memory Message Mailbox Controller

This block carries fixed-size messages in both directions between a host and an I/O coprocessor through a byte-wide shared RAM. The RAM is built into the block. The coprocessor reaches it through a plain byte port with combinational read data, and the block's own engine owns the other port. Each direction has seven channels. Each channel has a one-byte handshake state and a 32-byte slot. A reply is always written back into the slot that carried the request.

In the outbound direction the host hands over one request: a channel number and 32 message bytes. The engine waits until that channel's state byte reads idle. It then copies the message into the slot, marks the channel as new and pulses the coprocessor interrupt. It keeps polling until the coprocessor marks the channel complete. At that point it reads the reply out of the slot, gives the host a one-cycle done pulse and hands the channel back as idle.

In the inbound direction the engine scans the receive state bytes for a channel the coprocessor has marked new. It claims that channel, reads the message and presents it to the host as unsolicited. It then waits for the host's reply, writes the reply into the same slot, marks the channel complete and pulses the coprocessor interrupt. After reset the engine writes the channel counts and clears every state byte before it serves any traffic.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset the engine writes the value 7 to the outbound count byte (0x200) and to the inbound count byte (0x300), and writes 0 to the seven outbound state bytes (0x201+n) and the seven inbound state bytes (0x301+n). While reset is applied, snd_status is 0 (unused), and snd_done, cop_irq and rx_valid are low.
- R2: An snd_req pulse with snd_chan below 7 is accepted only when snd_status is 0 or 3, and snd_status reads 1 (waiting) in the next cycle. A request for channel 7, or any request made while snd_status is 1 or 2, is ignored: it changes neither the status, nor the message held for the pending request, nor any RAM byte.
- R3: For an accepted request on channel n, message byte k (snd_msg[8k+7:8k]) is written to address 0x220+32n+k. All 32 bytes are written before the state byte 0x201+n is set to 1 (new).
- R4: While the state byte of the requested channel reads anything other than 0 (idle), the request stays in status 1, and no byte of that channel's slot is written.
- R5: When the message is posted, the state byte becomes 1. In the following cycle cop_irq is high for exactly one cycle and snd_status becomes 2 (sent, awaiting reply).
- R6: Once the coprocessor writes 3 (complete) to the state byte, the engine reads the 32 slot bytes into snd_reply (byte k in bits 8k+7:8k) and writes 0 to the state byte. It raises snd_done for one cycle, in which snd_status becomes 3 (complete).
- R7: An inbound state byte 0x301+n that reads 1 is claimed: the engine writes 2 (received) to it and copies slot 0x320+32n+k into rx_msg byte k. It then raises rx_valid with rx_chan = n and rx_status = 6 (unsolicited), and holds them until rx_ack.
- R8: On rx_ack, rx_reply byte k is written to 0x320+32n+k and rx_valid falls. After all 32 bytes, the inbound state byte is written to 3, and cop_irq pulses for one cycle after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_req | input | 1 | One-cycle outbound request strobe |
| snd_chan | input | 3 | Outbound channel number, 0 to 6 |
| snd_msg | input | 256 | Outbound message, byte k in bits 8k+7:8k |
| snd_status | output | 3 | Outbound request status: 0 unused, 1 waiting, 2 sent, 3 complete |
| snd_done | output | 1 | One-cycle pulse when a reply has been collected |
| snd_reply | output | 256 | Reply bytes read from the slot |
| rx_valid | output | 1 | An inbound message is held for the host |
| rx_chan | output | 3 | Channel of the held inbound message |
| rx_msg | output | 256 | Held inbound message |
| rx_status | output | 3 | 6 while an inbound message is held, else 0 |
| rx_ack | input | 1 | Host accepts the inbound message and supplies its reply |
| rx_reply | input | 256 | Reply to the inbound message, sampled with rx_ack |
| cop_irq | output | 1 | One-cycle interrupt pulse to the coprocessor |
| cop_we | input | 1 | Coprocessor RAM write enable |
| cop_addr | input | 10 | Coprocessor RAM byte address |
| cop_wdata | input | 8 | Coprocessor RAM write data |
| cop_rdata | output | 8 | Coprocessor RAM read data, combinational |

## Verification
The bench holds an outbound channel's state byte at "received" and plants a marker in its slot. A design that skips the idle check overwrites the marker and posts over a transaction that is still live. While a request is outstanding, it fires a second request for another channel. A design that does not lock the request then swaps the held message or posts the second channel, and the bench sees this in the slot bytes, in the other channel's state byte or in an extra interrupt. A request for channel 7 shows whether the design decodes past the last slot. The inbound test confirms that a claimed channel reads "received" rather than staying "new", which would cause a second delivery, and that the reply lands in the same slot before the state byte turns complete.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Shared-memory geometry: fixed because the coprocessor decodes it.
  localparam int MBX_AW        = 10;
  localparam int MBX_MSG_BYTES = 32;
  localparam int MBX_IDX_W     = $clog2(MBX_MSG_BYTES);

  localparam logic [MBX_AW-1:0] OUT_CNT_A  = 10'h200;
  localparam logic [MBX_AW-1:0] OUT_SLOT_A = 10'h220;
  localparam logic [MBX_AW-1:0] IN_CNT_A   = 10'h300;
  localparam logic [MBX_AW-1:0] IN_SLOT_A  = 10'h320;

  // Channel handshake byte values
  localparam logic [7:0] CH_IDLE = 8'd0;
  localparam logic [7:0] CH_NEW  = 8'd1;
  localparam logic [7:0] CH_RCVD = 8'd2;
  localparam logic [7:0] CH_DONE = 8'd3;

  // Request status codes seen by the host
  localparam logic [2:0] RQ_UNUSED = 3'd0;
  localparam logic [2:0] RQ_WAIT   = 3'd1;
  localparam logic [2:0] RQ_SENT   = 3'd2;
  localparam logic [2:0] RQ_DONE   = 3'd3;
  localparam logic [2:0] RQ_UNSOL  = 3'd6;

  // Address of the handshake byte of channel ch
  function automatic logic [MBX_AW-1:0] state_addr(logic inbound, logic [2:0] ch);
    return (inbound ? IN_CNT_A : OUT_CNT_A) + MBX_AW'(ch) + MBX_AW'(1);
  endfunction

  // Address of byte k in the slot of channel ch
  function automatic logic [MBX_AW-1:0] slot_addr(logic inbound, logic [2:0] ch,
                                                  logic [MBX_IDX_W-1:0] k);
    return (inbound ? IN_SLOT_A : OUT_SLOT_A) + (MBX_AW'(ch) << MBX_IDX_W) + MBX_AW'(k);
  endfunction

  // Start-up sequence: step i walks out count, out states, in count, in states
  function automatic logic [MBX_AW-1:0] init_addr(logic [MBX_IDX_W-1:0] i, int nch);
    if (int'(i) <= nch) return OUT_CNT_A + MBX_AW'(i);
    return IN_CNT_A + MBX_AW'(int'(i) - nch - 1);
  endfunction

  function automatic logic [7:0] init_value(logic [MBX_IDX_W-1:0] i, int nch);
    return (int'(i) == 0 || int'(i) == nch + 1) ? 8'(nch) : 8'h00;
  endfunction
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int AW = mbx_pkg::MBX_AW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // Port a is the engine; on a same-address collision its write lands last.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];
endmodule

// File: rtl/mbx_slot_buf.sv
module mbx_slot_buf #(
  parameter int NBYTES = mbx_pkg::MBX_MSG_BYTES,
  localparam int IW    = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NBYTES*8-1:0] load_data,
  input  logic              bwr,
  input  logic [IW-1:0]     idx,
  input  logic [7:0]        bdata,
  output logic [NBYTES*8-1:0] data,
  output logic [7:0]        rd_byte
);
  logic [7:0] bytes_q [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bytes_q[g] <= 8'h00;
      else if (load)                    bytes_q[g] <= load_data[g*8 +: 8];
      else if (bwr && idx == IW'(g))    bytes_q[g] <= bdata;
    end
    assign data[g*8 +: 8] = bytes_q[g];
  end

  assign rd_byte = bytes_q[idx];
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int NCH = 7,
  localparam int AW = MBX_AW,
  localparam int IW = MBX_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snd_req,
  input  logic [2:0]    snd_chan,
  output logic [2:0]    snd_status,
  output logic          snd_done,
  output logic          cop_irq,
  input  logic          rx_ack,
  output logic          rx_valid,
  output logic [2:0]    rx_chan,
  output logic          tx_load,
  output logic          tx_bwr,
  output logic          rx_load,
  output logic          rx_bwr,
  output logic [IW-1:0] b_idx,
  input  logic [7:0]    tx_byte,
  input  logic [7:0]    rx_byte,
  output logic          e_we,
  output logic [AW-1:0] e_addr,
  output logic [7:0]    e_wdata,
  input  logic [7:0]    e_rdata,
  output logic          ev_tx_wr,
  output logic          ev_tx_post,
  output logic          ev_tx_fin,
  output logic          ev_rx_post
);
  localparam logic [2:0]    NCH_C     = 3'(NCH);
  localparam logic [2:0]    LAST_CH   = 3'(NCH - 1);
  localparam logic [IW-1:0] LAST_BYTE = IW'(MBX_MSG_BYTES - 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(2 * NCH + 1);

  typedef enum logic [3:0] {
    ST_INIT, ST_IDLE,
    ST_TX_WR, ST_TX_POST, ST_TX_RD, ST_TX_FIN,
    ST_RX_CLAIM, ST_RX_RD, ST_RX_HOLD, ST_RX_WR, ST_RX_POST
  } eng_st_e;

  eng_st_e       st;
  logic [IW-1:0] idx;
  logic          poll_rx;
  logic [2:0]    tx_chan;
  logic [2:0]    rx_idx;
  logic          tx_pend;
  logic          look_tx;
  logic          last_byte;

  assign tx_pend   = (snd_status == RQ_WAIT) || (snd_status == RQ_SENT);
  assign look_tx   = tx_pend && !poll_rx;
  assign last_byte = (idx == LAST_BYTE);
  assign tx_load   = snd_req && (snd_chan < NCH_C) && !tx_pend;
  assign rx_load   = (st == ST_RX_HOLD) && rx_ack;
  assign tx_bwr    = (st == ST_TX_RD);
  assign rx_bwr    = (st == ST_RX_RD);
  assign b_idx     = idx;

  assign ev_tx_wr   = (st == ST_TX_WR);
  assign ev_tx_post = (st == ST_TX_POST);
  assign ev_tx_fin  = (st == ST_TX_FIN);
  assign ev_rx_post = (st == ST_RX_POST);

  // RAM port drive per engine state
  always_comb begin
    e_we    = 1'b0;
    e_addr  = '0;
    e_wdata = 8'h00;
    unique case (st)
      ST_INIT: begin
        e_we    = 1'b1;
        e_addr  = init_addr(idx, NCH);
        e_wdata = init_value(idx, NCH);
      end
      ST_IDLE:     e_addr = look_tx ? state_addr(1'b0, tx_chan) : state_addr(1'b1, rx_idx);
      ST_TX_WR: begin
        e_we    = 1'b1;
        e_addr  = slot_addr(1'b0, tx_chan, idx);
        e_wdata = tx_byte;
      end
      ST_TX_POST: begin
        e_we    = 1'b1;
        e_addr  = state_addr(1'b0, tx_chan);
        e_wdata = CH_NEW;
      end
      ST_TX_RD:    e_addr = slot_addr(1'b0, tx_chan, idx);
      ST_TX_FIN: begin
        e_we    = 1'b1;
        e_addr  = state_addr(1'b0, tx_chan);
        e_wdata = CH_IDLE;
      end
      ST_RX_CLAIM: begin
        e_we    = 1'b1;
        e_addr  = state_addr(1'b1, rx_chan);
        e_wdata = CH_RCVD;
      end
      ST_RX_RD:    e_addr = slot_addr(1'b1, rx_chan, idx);
      ST_RX_HOLD:  e_addr = state_addr(1'b1, rx_chan);
      ST_RX_WR: begin
        e_we    = 1'b1;
        e_addr  = slot_addr(1'b1, rx_chan, idx);
        e_wdata = rx_byte;
      end
      ST_RX_POST: begin
        e_we    = 1'b1;
        e_addr  = state_addr(1'b1, rx_chan);
        e_wdata = CH_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_INIT;
      idx        <= '0;
      poll_rx    <= 1'b0;
      tx_chan    <= 3'd0;
      rx_idx     <= 3'd0;
      rx_chan    <= 3'd0;
      rx_valid   <= 1'b0;
      snd_status <= RQ_UNUSED;
      snd_done   <= 1'b0;
      cop_irq    <= 1'b0;
    end else begin
      snd_done <= 1'b0;
      cop_irq  <= 1'b0;
      if (tx_load) begin
        tx_chan    <= snd_chan;
        snd_status <= RQ_WAIT;
      end
      unique case (st)
        ST_INIT: begin
          if (idx == INIT_LAST) begin
            st  <= ST_IDLE;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_IDLE: begin
          poll_rx <= ~poll_rx;
          idx     <= '0;
          if (look_tx) begin
            if (snd_status == RQ_WAIT && e_rdata == CH_IDLE)      st <= ST_TX_WR;
            else if (snd_status == RQ_SENT && e_rdata == CH_DONE) st <= ST_TX_RD;
          end else if (e_rdata == CH_NEW) begin
            rx_chan <= rx_idx;
            st      <= ST_RX_CLAIM;
          end else begin
            rx_idx <= (rx_idx == LAST_CH) ? 3'd0 : rx_idx + 3'd1;
          end
        end
        ST_TX_WR: begin
          idx <= idx + 1'b1;
          if (last_byte) st <= ST_TX_POST;
        end
        ST_TX_POST: begin
          snd_status <= RQ_SENT;
          cop_irq    <= 1'b1;
          st         <= ST_IDLE;
        end
        ST_TX_RD: begin
          idx <= idx + 1'b1;
          if (last_byte) st <= ST_TX_FIN;
        end
        ST_TX_FIN: begin
          snd_status <= RQ_DONE;
          snd_done   <= 1'b1;
          st         <= ST_IDLE;
        end
        ST_RX_CLAIM: st <= ST_RX_RD;
        ST_RX_RD: begin
          idx <= idx + 1'b1;
          if (last_byte) begin
            rx_valid <= 1'b1;
            st       <= ST_RX_HOLD;
          end
        end
        ST_RX_HOLD: begin
          if (rx_ack) begin
            rx_valid <= 1'b0;
            st       <= ST_RX_WR;
          end
        end
        ST_RX_WR: begin
          idx <= idx + 1'b1;
          if (last_byte) st <= ST_RX_POST;
        end
        ST_RX_POST: begin
          cop_irq <= 1'b1;
          rx_idx  <= (rx_idx == LAST_CH) ? 3'd0 : rx_idx + 3'd1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NCH = 7,
  localparam int AW = MBX_AW,
  localparam int MW = MBX_MSG_BYTES * 8,
  localparam int IW = MBX_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snd_req,
  input  logic [2:0]    snd_chan,
  input  logic [MW-1:0] snd_msg,
  output logic [2:0]    snd_status,
  output logic          snd_done,
  output logic [MW-1:0] snd_reply,
  output logic          rx_valid,
  output logic [2:0]    rx_chan,
  output logic [MW-1:0] rx_msg,
  output logic [2:0]    rx_status,
  input  logic          rx_ack,
  input  logic [MW-1:0] rx_reply,
  output logic          cop_irq,
  input  logic          cop_we,
  input  logic [AW-1:0] cop_addr,
  input  logic [7:0]    cop_wdata,
  output logic [7:0]    cop_rdata
);
  logic          e_we;
  logic [AW-1:0] e_addr;
  logic [7:0]    e_wdata;
  logic [7:0]    e_rdata;
  logic          tx_load, tx_bwr, rx_load, rx_bwr;
  logic [IW-1:0] b_idx;
  logic [7:0]    tx_byte, rx_byte;
  logic          ev_tx_wr, ev_tx_post, ev_tx_fin, ev_rx_post;

  mbx_ram #(.AW(AW)) u_ram (
    .clk     (clk),
    .a_we    (e_we),
    .a_addr  (e_addr),
    .a_wdata (e_wdata),
    .a_rdata (e_rdata),
    .b_we    (cop_we),
    .b_addr  (cop_addr),
    .b_wdata (cop_wdata),
    .b_rdata (cop_rdata)
  );

  // Outbound slot copy: holds the message, then the reply overwrites it
  mbx_slot_buf #(.NBYTES(MBX_MSG_BYTES)) u_tx_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_data (snd_msg),
    .bwr       (tx_bwr),
    .idx       (b_idx),
    .bdata     (e_rdata),
    .data      (snd_reply),
    .rd_byte   (tx_byte)
  );

  // Inbound slot copy: holds the message, then the host reply
  mbx_slot_buf #(.NBYTES(MBX_MSG_BYTES)) u_rx_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rx_load),
    .load_data (rx_reply),
    .bwr       (rx_bwr),
    .idx       (b_idx),
    .bdata     (e_rdata),
    .data      (rx_msg),
    .rd_byte   (rx_byte)
  );

  mbx_engine #(.NCH(NCH)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .snd_req    (snd_req),
    .snd_chan   (snd_chan),
    .snd_status (snd_status),
    .snd_done   (snd_done),
    .cop_irq    (cop_irq),
    .rx_ack     (rx_ack),
    .rx_valid   (rx_valid),
    .rx_chan    (rx_chan),
    .tx_load    (tx_load),
    .tx_bwr     (tx_bwr),
    .rx_load    (rx_load),
    .rx_bwr     (rx_bwr),
    .b_idx      (b_idx),
    .tx_byte    (tx_byte),
    .rx_byte    (rx_byte),
    .e_we       (e_we),
    .e_addr     (e_addr),
    .e_wdata    (e_wdata),
    .e_rdata    (e_rdata),
    .ev_tx_wr   (ev_tx_wr),
    .ev_tx_post (ev_tx_post),
    .ev_tx_fin  (ev_tx_fin),
    .ev_rx_post (ev_rx_post)
  );

  assign rx_status = rx_valid ? RQ_UNSOL : RQ_UNUSED;
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       e_we,
  input logic [9:0] e_addr,
  input logic [7:0] e_wdata,
  input logic [2:0] snd_status,
  input logic       snd_done,
  input logic       cop_irq,
  input logic       rx_valid,
  input logic       rx_ack,
  input logic       ev_tx_wr,
  input logic       ev_tx_post,
  input logic       ev_tx_fin,
  input logic       ev_rx_post
);
  // R1
  write_in_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |-> (e_addr >= 10'h200));

  // R2
  sent_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_status == 3'd2) && !ev_tx_fin |=> (snd_status == 3'd2));

  // R3
  post_after_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_post |-> $past(ev_tx_wr));

  // R4
  slot_write_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_wr |-> (snd_status == 3'd1));

  // R5
  post_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_post |-> e_we && (e_wdata == 8'd1) ##1 cop_irq && (snd_status == 3'd2));

  // R6
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_fin |-> e_we && (e_wdata == 8'd0) ##1 snd_done && (snd_status == 3'd3));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_done |=> !snd_done);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ack |=> rx_valid);

  // R8
  rx_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_post |-> e_we && (e_wdata == 8'd3) ##1 cop_irq && !rx_valid);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_irq |=> !cop_irq);
endmodule

bind mbx_ctrl mbx_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .e_we       (e_we),
  .e_addr     (e_addr),
  .e_wdata    (e_wdata),
  .snd_status (snd_status),
  .snd_done   (snd_done),
  .cop_irq    (cop_irq),
  .rx_valid   (rx_valid),
  .rx_ack     (rx_ack),
  .ev_tx_wr   (ev_tx_wr),
  .ev_tx_post (ev_tx_post),
  .ev_tx_fin  (ev_tx_fin),
  .ev_rx_post (ev_rx_post)
);

// File: tb/tb_mbx_ctrl.sv
module tb_mbx_ctrl;
  localparam int CLK_P = 10;
  localparam int NV    = 6;
  // {channel, seed}
  localparam logic [15:0] VEC [0:NV-1] = '{16'h0011, 16'h0622, 16'h0233,
                                           16'h0044, 16'h0455, 16'h0166};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         snd_req = 1'b0;
  logic [2:0]   snd_chan = 3'd0;
  logic [255:0] snd_msg = '0;
  logic [2:0]   snd_status;
  logic         snd_done;
  logic [255:0] snd_reply;
  logic         rx_valid;
  logic [2:0]   rx_chan;
  logic [255:0] rx_msg;
  logic [2:0]   rx_status;
  logic         rx_ack = 1'b0;
  logic [255:0] rx_reply = '0;
  logic         cop_irq;
  logic         cop_we = 1'b0;
  logic [9:0]   cop_addr = '0;
  logic [7:0]   cop_wdata = '0;
  logic [7:0]   cop_rdata;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;

  mbx_ctrl dut (.*);

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (cop_irq) irq_cnt++;

  function automatic logic [7:0] mbyte(int seed, int k);
    return 8'((seed * 13 + k * 7 + 1) & 255);
  endfunction
  function automatic logic [7:0] rbyte(int seed, int k);
    return 8'(((seed * 29) ^ 200) + k * 5);
  endfunction
  function automatic logic [9:0] out_slot(int ch, int k);
    return 10'(512 + 32 + ch * 32 + k);
  endfunction
  function automatic logic [9:0] in_slot(int ch, int k);
    return 10'(768 + 32 + ch * 32 + k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cop_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    cop_addr = a; cop_wdata = d; cop_we = 1'b1;
    @(negedge clk);
    cop_we = 1'b0;
  endtask

  task automatic cop_rd(input logic [9:0] a, output logic [7:0] d);
    cop_addr = a;
    #1;
    d = cop_rdata;
  endtask

  task automatic pulse_req(input int ch, input int seed);
    @(negedge clk);
    snd_req = 1'b1; snd_chan = 3'(ch);
    for (int k = 0; k < 32; k++) snd_msg[k*8 +: 8] = mbyte(seed, k);
    @(negedge clk);
    snd_req = 1'b0;
  endtask

  task automatic wait_sent(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (snd_status == 3'd2) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // Coprocessor side of one outbound transaction, from post to completion
  task automatic finish_send(input int ch, input int seed, input int irq_before);
    bit ok;
    int mism;
    logic [7:0] b;
    logic [255:0] exp_rep;
    wait_sent(ok);
    chk(ok, "R5", "status reaches sent", snd_status, 2);
    mism = 0;
    for (int k = 0; k < 32; k++) begin
      cop_rd(out_slot(ch, k), b);
      if (b != mbyte(seed, k)) mism++;
    end
    chk(mism == 0, "R3", "slot bytes mismatching", mism, 0);
    cop_rd(10'(513 + ch), b);
    chk(b == 8'd1, "R5", "state byte after post", b, 1);
    chk(irq_cnt == irq_before + 1, "R5", "cop_irq pulses", irq_cnt, irq_before + 1);
    for (int k = 0; k < 32; k++) begin
      cop_wr(out_slot(ch, k), rbyte(seed, k));
      exp_rep[k*8 +: 8] = rbyte(seed, k);
    end
    cop_wr(10'(513 + ch), 8'd3);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (snd_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok, "R6", "done pulse seen", 0, 1);
    chk(snd_reply == exp_rep, "R6", "reply bytes", snd_reply[63:0], exp_rep[63:0]);
    chk(snd_status == 3'd3, "R6", "status complete", snd_status, 3);
    cop_rd(10'(513 + ch), b);
    chk(b == 8'd0, "R6", "state byte released", b, 0);
    @(negedge clk);
    chk(!snd_done, "R6", "done one cycle", snd_done, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int mism;
    int ib;
    bit ok;
    logic [255:0] exp_msg;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(snd_status == 3'd0, "R1", "status in reset", snd_status, 0);
    chk(!snd_done && !cop_irq && !rx_valid, "R1", "pulses in reset",
        {snd_done, cop_irq, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    cop_rd(10'h200, b);
    chk(b == 8'd7, "R1", "out count byte", b, 7);
    cop_rd(10'h300, b);
    chk(b == 8'd7, "R1", "in count byte", b, 7);
    mism = 0;
    for (int n = 0; n < 7; n++) begin
      cop_rd(10'(513 + n), b); if (b != 0) mism++;
      cop_rd(10'(769 + n), b); if (b != 0) mism++;
    end
    chk(mism == 0, "R1", "nonzero state bytes", mism, 0);

    // R2 channel 7 ignored
    ib = irq_cnt;
    pulse_req(7, 9);
    repeat (60) @(negedge clk);
    chk(snd_status == 3'd0, "R2", "channel 7 status", snd_status, 0);
    chk(irq_cnt == ib, "R2", "channel 7 irq", irq_cnt, ib);

    // Table-driven outbound transactions
    for (int v = 0; v < NV; v++) begin
      int ch = int'(VEC[v][10:8]);
      int sd = int'(VEC[v][7:0]);
      ib = irq_cnt;
      pulse_req(ch, sd);
      chk(snd_status == 3'd1, "R2", "status waiting after accept", snd_status, 1);
      finish_send(ch, sd, ib);
    end

    // R4 busy channel held
    cop_wr(10'(513 + 3), 8'd2);
    cop_wr(out_slot(3, 0), 8'hEE);
    ib = irq_cnt;
    pulse_req(3, 77);
    repeat (80) @(negedge clk);
    chk(snd_status == 3'd1, "R4", "status while busy", snd_status, 1);
    cop_rd(out_slot(3, 0), b);
    chk(b == 8'hEE, "R4", "slot untouched while busy", b, 8'hEE);
    cop_wr(10'(513 + 3), 8'd0);
    wait_sent(ok);
    // R2 second request during sent is ignored
    pulse_req(5, 99);
    chk(snd_status == 3'd2, "R2", "status kept on extra request", snd_status, 2);
    finish_send(3, 77, ib);
    repeat (80) @(negedge clk);
    cop_rd(10'(513 + 5), b);
    chk(b == 8'd0, "R2", "ignored channel state", b, 0);
    chk(snd_status == 3'd3 && irq_cnt == ib + 1, "R2", "no extra post",
        irq_cnt, ib + 1);

    // R7/R8 inbound message on channel 4
    for (int k = 0; k < 32; k++) begin
      cop_wr(in_slot(4, k), mbyte(150, k));
      exp_msg[k*8 +: 8] = mbyte(150, k);
    end
    ib = irq_cnt;
    cop_wr(10'(769 + 4), 8'd1);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (rx_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok, "R7", "rx_valid raised", 0, 1);
    chk(rx_chan == 3'd4, "R7", "rx_chan", rx_chan, 4);
    chk(rx_msg == exp_msg, "R7", "rx_msg", rx_msg[63:0], exp_msg[63:0]);
    chk(rx_status == 3'd6, "R7", "rx_status", rx_status, 6);
    cop_rd(10'(769 + 4), b);
    chk(b == 8'd2, "R7", "inbound state claimed", b, 2);
    repeat (10) @(negedge clk);
    chk(rx_valid, "R7", "rx_valid held", rx_valid, 1);
    for (int k = 0; k < 32; k++) rx_reply[k*8 +: 8] = rbyte(150, k);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    chk(!rx_valid, "R8", "rx_valid drops", rx_valid, 0);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      cop_rd(10'(769 + 4), b);
      if (b == 8'd3) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok, "R8", "inbound state complete", b, 3);
    mism = 0;
    for (int k = 0; k < 32; k++) begin
      cop_rd(in_slot(4, k), b);
      if (b != rbyte(150, k)) mism++;
    end
    chk(mism == 0, "R8", "reply bytes in slot mismatching", mism, 0);
    @(negedge clk);
    #1;
    chk(irq_cnt == ib + 1, "R8", "cop_irq after reply", irq_cnt, ib + 1);
    cop_wr(10'(769 + 4), 8'd0);
    repeat (40) @(negedge clk);
    chk(!rx_valid, "R7", "no redelivery after idle", rx_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule